// File: doc/BRIEF.md
# TPM FIFO Command/Response Sequencer

This block carries one complete command/response exchange with a trusted platform module that exposes a FIFO-style register interface. A caller places a command in an external buffer, gives its size, the largest response it will accept and the cached vendor identifier, then pulses `start`. The sequencer reads the buffer through a combinational byte-read port. It checks the command's self-declared length and then reaches the device through a register transaction port. An agent below that port splits long transfers by burst count. The sequencer itself works in whole-register transfers.

On the bus side the sequencer signals command-ready, streams the command into the data FIFO, issues go and polls the status register at a fixed interval until the response is available. It reads the 6-byte response header and takes the length from it. It then reads all but the last byte, checks status, reads the last byte, checks status again and finally returns the device to idle. Response bytes leave on a valid/ready stream. When `rsp_ready` is low, `rsp_valid` and `rsp_data` hold and the bus read stalls, so no byte is lost or repeated. The exchange ends with a one-cycle `done`, a result code and, on success, the response length.

The transaction port uses three handshakes. A request (`txn_*`) names the register, the direction and the byte count. Write bytes follow on `wr_*` and read bytes come back on `rd_*`. A request is complete after exactly `txn_len` byte handshakes. Status is carried as one byte: bit 7 status-valid, bit 6 command-ready, bit 5 go, bit 4 data-available.

Top module: `tpm_fifo_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `txn_valid` and `rsp_valid` are low.
- R2: A `start` with `vendor_id` equal to zero ends with `done` and result code 1, and no transaction request is made.
- R3: The command's length field is the big-endian 32-bit value at buffer bytes 2 to 5. If it differs from `cmd_size`, or if `cmd_size` is below 6, the exchange ends with result code 2 before any transaction request.
- R4: A valid command produces, in order, a one-byte status write of 0x40, a FIFO write of `cmd_size` bytes in buffer order, and a one-byte status write of 0x20.
- R5: After go, the status register is read with at least `POLL_CYCLES` cycles between consecutive poll requests, until a read shows both bit 7 and bit 4 set. No FIFO read starts before a status read has shown both bits set.
- R6: If a poll read still lacks either bit after `TIMEOUT_CYCLES` cycles of waiting, the exchange ends with result code 3 and no FIFO read.
- R7: The first FIFO read is 6 bytes long, and the response length is the big-endian value in header bytes 2 to 5. A length below 7 or above `max_rsp` ends the exchange with result code 4, after the 6 header bytes have been streamed.
- R8: For a valid length L, a FIFO read of L−7 bytes follows (skipped when L is 7), then a status read. If that read does not show both bit 7 and bit 4 set, the result is code 5.
- R9: A one-byte FIFO read of the last byte follows, then a status read that must show bit 7 set and bit 4 clear. Otherwise the result is code 6 and no further status write is made.
- R10: On success a final status write of 0x40 is made, then `done` pulses for one cycle with result code 0 and `rsp_len` = L. `busy` stays high from the accepted `start` until `done`.
- R11: Every response byte read from the FIFO appears once, in order, on the response stream, and the stream data holds while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an exchange (ignored while busy) |
| cmd_size | input | LEN_W | Command size in bytes |
| max_rsp | input | LEN_W | Largest acceptable response length |
| vendor_id | input | 16 | Cached vendor identifier; zero means not initialised |
| cmd_rd_addr | output | LEN_W | Byte address into the command buffer |
| cmd_rd_data | input | 8 | Command buffer byte at `cmd_rd_addr` (combinational) |
| txn_valid | output | 1 | Transaction request valid |
| txn_ready | input | 1 | Transaction request accepted |
| txn_write | output | 1 | 1 = write, 0 = read |
| txn_fifo | output | 1 | 1 = data FIFO register, 0 = status register |
| txn_len | output | LEN_W | Byte count of the transaction |
| wr_data | output | 8 | Write byte |
| wr_valid | output | 1 | Write byte valid |
| wr_ready | input | 1 | Write byte accepted |
| rd_data | input | 8 | Read byte |
| rd_valid | input | 1 | Read byte valid |
| rd_ready | output | 1 | Read byte accepted |
| rsp_data | output | 8 | Response stream byte |
| rsp_valid | output | 1 | Response stream valid |
| rsp_ready | input | 1 | Response stream ready |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| result | output | 3 | Result code (0 ok, 1 uninitialised, 2 size, 3 timeout, 4 response length, 5 mid status, 6 final status) |
| rsp_len | output | LEN_W | Response length on success, else 0 |

## Verification
The bench checks that a rejected command makes no bus activity at all. A design that checked the length after signalling command-ready would wake the device for a command it then drops. The 7-byte response exercises the skipped middle read: an off-by-one in the L−7 count would issue a zero-length or wrap-around transfer and hang or over-read. Separate device faults corrupt the status before the final byte and after it, which shows whether each check tests the right bit pattern and whether a failed final check still wrongly sends the idle write. A response length over the limit, one under 7, a never-ready device, and response back-pressure check the abort points, the timeout path, and that no stream byte is dropped or duplicated.

// File: rtl/tpm_seq_pkg.sv
package tpm_seq_pkg;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_UNINIT  = 3'd1,
    RES_SIZE    = 3'd2,
    RES_TIMEOUT = 3'd3,
    RES_RSP_LEN = 3'd4,
    RES_MID_STS = 3'd5,
    RES_FIN_STS = 3'd6
  } seq_result_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_CMP, S_W_RDY, S_W_CMD, S_W_GO, S_WAIT, S_POLL,
    S_HDR, S_LCHK, S_BODY, S_MID, S_LAST, S_FIN, S_IDLEW
  } seq_state_e;

  localparam logic [7:0] STS_VALID   = 8'h80;
  localparam logic [7:0] STS_CMD_RDY = 8'h40;
  localparam logic [7:0] STS_GO      = 8'h20;
  localparam logic [7:0] STS_AVAIL   = 8'h10;
  localparam logic [7:0] STS_MASK    = STS_VALID | STS_AVAIL;
  localparam int         HDR_BYTES   = 6;

endpackage

// File: rtl/tpm_seq_mover.sv
module tpm_seq_mover #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_write,
  input  logic             go_fifo,
  input  logic [LEN_W-1:0] go_len,
  input  logic [7:0]       wr_byte,
  input  logic             sink_ready,
  output logic             done,
  output logic [LEN_W-1:0] idx,
  output logic             rd_phase,
  output logic             rd_fire,
  output logic             txn_valid,
  input  logic             txn_ready,
  output logic             txn_write,
  output logic             txn_fifo,
  output logic [LEN_W-1:0] txn_len,
  output logic [7:0]       wr_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  input  logic             rd_valid,
  output logic             rd_ready
);
  typedef enum logic [1:0] {MV_IDLE, MV_REQ, MV_DATA} mv_state_e;

  mv_state_e        ph;
  logic             wr_q, fifo_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic             byte_fire;

  assign txn_valid = (ph == MV_REQ);
  assign txn_write = wr_q;
  assign txn_fifo  = fifo_q;
  assign txn_len   = len_q;
  assign wr_valid  = (ph == MV_DATA) && wr_q;
  assign wr_data   = wr_byte;
  assign rd_phase  = (ph == MV_DATA) && !wr_q;
  assign rd_ready  = rd_phase && sink_ready;
  assign rd_fire   = rd_valid && rd_ready;
  assign byte_fire = (wr_valid && wr_ready) || rd_fire;
  assign idx       = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= MV_IDLE;
      wr_q   <= 1'b0;
      fifo_q <= 1'b0;
      len_q  <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        MV_IDLE: if (go) begin
          wr_q   <= go_write;
          fifo_q <= go_fifo;
          len_q  <= go_len;
          cnt    <= '0;
          if (go_len == '0) done <= 1'b1;
          else              ph   <= MV_REQ;
        end
        MV_REQ: if (txn_ready) ph <= MV_DATA;
        MV_DATA: if (byte_fire) begin
          cnt <= cnt + 1'b1;
          if (cnt == len_q - 1'b1) begin
            ph   <= MV_IDLE;
            done <= 1'b1;
          end
        end
        default: ph <= MV_IDLE;
      endcase
    end
  end

  AST_TXN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_len) && $stable(txn_write) && $stable(txn_fifo)); // R4
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_ready)); // R4
endmodule

// File: rtl/tpm_seq_timer.sv
module tpm_seq_timer #(
  parameter int unsigned     POLL_CYCLES    = 125000,
  parameter longint unsigned TIMEOUT_CYCLES = 64'd15000000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic clr_poll,
  input  logic poll_run,
  input  logic wait_run,
  output logic poll_due,
  output logic expired
);
  localparam int PW = $clog2(POLL_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_CYCLES - 1);
  localparam logic [TW-1:0] TO_LIM    = TW'(TIMEOUT_CYCLES);

  logic [PW-1:0] poll_cnt;
  logic [TW-1:0] tot_cnt;

  assign poll_due = (poll_cnt == POLL_LAST);
  assign expired  = (tot_cnt >= TO_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      poll_cnt <= '0;
      tot_cnt  <= '0;
    end else begin
      if (clr_poll)                  poll_cnt <= '0;
      else if (poll_run && !poll_due) poll_cnt <= poll_cnt + 1'b1;
      if (wait_run && !expired)       tot_cnt  <= tot_cnt + 1'b1;
    end
  end

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !clr_all |=> expired); // R6
endmodule

// File: rtl/tpm_seq_be_acc.sv
module tpm_seq_be_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) value <= '0;
    else if (en)       value <= {value[23:0], din};
  end
endmodule

// File: rtl/tpm_fifo_sequencer.sv
module tpm_fifo_sequencer
  import tpm_seq_pkg::*;
#(
  parameter int              LEN_W          = 12,
  parameter int unsigned     POLL_CYCLES    = 125000,
  parameter longint unsigned TIMEOUT_CYCLES = 64'd15000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cmd_size,
  input  logic [LEN_W-1:0] max_rsp,
  input  logic [15:0]      vendor_id,
  output logic [LEN_W-1:0] cmd_rd_addr,
  input  logic [7:0]       cmd_rd_data,
  output logic             txn_valid,
  input  logic             txn_ready,
  output logic             txn_write,
  output logic             txn_fifo,
  output logic [LEN_W-1:0] txn_len,
  output logic [7:0]       wr_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  input  logic [7:0]       rd_data,
  input  logic             rd_valid,
  output logic             rd_ready,
  output logic [7:0]       rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             busy,
  output logic             done,
  output logic [2:0]       result,
  output logic [LEN_W-1:0] rsp_len
);
  localparam logic [31:0]      MIN_RSP   = 32'(HDR_BYTES + 1);
  localparam logic [LEN_W-1:0] HDR_LEN   = LEN_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] TAIL_SKIP = LEN_W'(HDR_BYTES + 1);

  seq_state_e  st, st_n;
  seq_result_e fin_code;
  logic        fin;
  logic [1:0]  k;
  logic [7:0]  sts_q;
  logic [31:0] acc;

  logic             mv_go, mv_w, mv_f, mv_done, mv_rd_phase, mv_rd_fire;
  logic [LEN_W-1:0] mv_len, mv_idx;
  logic [7:0]       wr_byte;
  logic             route, sink_ready;
  logic             acc_clr, acc_en;
  logic [7:0]       acc_din;
  logic             tmr_clr, poll_clr, poll_due, expired;
  logic             size_bad, len_bad;
  logic [LEN_W-1:0] tail_len;

  assign route      = (st == S_HDR) || (st == S_BODY) || (st == S_LAST);
  assign sink_ready = route ? rsp_ready : 1'b1;
  assign rsp_valid  = route && mv_rd_phase && rd_valid;
  assign rsp_data   = rd_data;
  assign busy       = (st != S_IDLE);

  always_comb begin
    if (st == S_CHK)        cmd_rd_addr = LEN_W'(k) + LEN_W'(2);
    else if (st == S_W_CMD) cmd_rd_addr = mv_idx;
    else                    cmd_rd_addr = '0;
  end

  always_comb begin
    if (st == S_W_CMD)     wr_byte = cmd_rd_data;
    else if (st == S_W_GO) wr_byte = STS_GO;
    else                   wr_byte = STS_CMD_RDY;
  end

  assign acc_din  = (st == S_CHK) ? cmd_rd_data : rd_data;
  assign acc_en   = (st == S_CHK) || ((st == S_HDR) && mv_rd_fire && (mv_idx >= LEN_W'(2)));
  assign size_bad = (cmd_size < HDR_LEN) || (acc != 32'(cmd_size));
  assign len_bad  = (acc < MIN_RSP) || (acc > 32'(max_rsp));
  assign tail_len = acc[LEN_W-1:0] - TAIL_SKIP;

  always_comb begin
    st_n     = st;
    mv_go    = 1'b0;
    mv_w     = 1'b0;
    mv_f     = 1'b0;
    mv_len   = '0;
    fin      = 1'b0;
    fin_code = RES_OK;
    tmr_clr  = 1'b0;
    poll_clr = 1'b0;
    acc_clr  = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        acc_clr = 1'b1;
        if (vendor_id == 16'h0) begin fin = 1'b1; fin_code = RES_UNINIT; end
        else st_n = S_CHK;
      end
      S_CHK: if (k == 2'd3) st_n = S_CMP;
      S_CMP: begin
        if (size_bad) begin fin = 1'b1; fin_code = RES_SIZE; end
        else begin mv_go = 1'b1; mv_w = 1'b1; mv_len = LEN_W'(1); st_n = S_W_RDY; end
      end
      S_W_RDY: if (mv_done) begin
        mv_go = 1'b1; mv_w = 1'b1; mv_f = 1'b1; mv_len = cmd_size; st_n = S_W_CMD;
      end
      S_W_CMD: if (mv_done) begin
        mv_go = 1'b1; mv_w = 1'b1; mv_len = LEN_W'(1); st_n = S_W_GO;
      end
      S_W_GO: if (mv_done) begin tmr_clr = 1'b1; st_n = S_WAIT; end
      S_WAIT: if (poll_due) begin mv_go = 1'b1; mv_len = LEN_W'(1); st_n = S_POLL; end
      S_POLL: if (mv_done) begin
        if ((sts_q & STS_MASK) == STS_MASK) begin
          mv_go = 1'b1; mv_f = 1'b1; mv_len = HDR_LEN; acc_clr = 1'b1; st_n = S_HDR;
        end else if (expired) begin
          fin = 1'b1; fin_code = RES_TIMEOUT;
        end else begin
          poll_clr = 1'b1; st_n = S_WAIT;
        end
      end
      S_HDR: if (mv_done) st_n = S_LCHK;
      S_LCHK: begin
        if (len_bad) begin fin = 1'b1; fin_code = RES_RSP_LEN; end
        else if (tail_len == '0) begin mv_go = 1'b1; mv_len = LEN_W'(1); st_n = S_MID; end
        else begin mv_go = 1'b1; mv_f = 1'b1; mv_len = tail_len; st_n = S_BODY; end
      end
      S_BODY: if (mv_done) begin mv_go = 1'b1; mv_len = LEN_W'(1); st_n = S_MID; end
      S_MID: if (mv_done) begin
        if ((sts_q & STS_MASK) == STS_MASK) begin
          mv_go = 1'b1; mv_f = 1'b1; mv_len = LEN_W'(1); st_n = S_LAST;
        end else begin fin = 1'b1; fin_code = RES_MID_STS; end
      end
      S_LAST: if (mv_done) begin mv_go = 1'b1; mv_len = LEN_W'(1); st_n = S_FIN; end
      S_FIN: if (mv_done) begin
        if ((sts_q & STS_MASK) == STS_VALID) begin
          mv_go = 1'b1; mv_w = 1'b1; mv_len = LEN_W'(1); st_n = S_IDLEW;
        end else begin fin = 1'b1; fin_code = RES_FIN_STS; end
      end
      S_IDLEW: if (mv_done) begin fin = 1'b1; fin_code = RES_OK; end
      default: st_n = S_IDLE;
    endcase
    if (fin) st_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      k       <= '0;
      sts_q   <= '0;
      done    <= 1'b0;
      result  <= '0;
      rsp_len <= '0;
    end else begin
      st   <= st_n;
      done <= fin;
      if (fin) begin
        result  <= fin_code;
        rsp_len <= (fin_code == RES_OK) ? acc[LEN_W-1:0] : '0;
      end
      if (st == S_IDLE)     k <= '0;
      else if (st == S_CHK) k <= k + 1'b1;
      if (mv_rd_fire && ((st == S_POLL) || (st == S_MID) || (st == S_FIN)))
        sts_q <= rd_data;
    end
  end

  tpm_seq_mover #(.LEN_W(LEN_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .go(mv_go), .go_write(mv_w), .go_fifo(mv_f),
    .go_len(mv_len), .wr_byte(wr_byte), .sink_ready(sink_ready), .done(mv_done),
    .idx(mv_idx), .rd_phase(mv_rd_phase), .rd_fire(mv_rd_fire),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_write(txn_write),
    .txn_fifo(txn_fifo), .txn_len(txn_len), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready)
  );

  tpm_seq_timer #(.POLL_CYCLES(POLL_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_all(tmr_clr), .clr_poll(poll_clr),
    .poll_run(st == S_WAIT), .wait_run((st == S_WAIT) || (st == S_POLL)),
    .poll_due(poll_due), .expired(expired)
  );

  tpm_seq_be_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en), .din(acc_din), .value(acc)
  );

  AST_QUIET_BEFORE_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_CHK || st == S_CMP) |-> !txn_valid); // R3
  AST_FIFO_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_fifo && !txn_write |-> (sts_q & STS_MASK) == STS_MASK); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R11
endmodule

// File: tb/tb_tpm_fifo_sequencer.sv
module tb_tpm_fifo_sequencer;
  localparam int LEN_W = 12;
  localparam int POLL  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             start = 1'b0;
  logic [LEN_W-1:0] cmd_size = '0, max_rsp = '0;
  logic [15:0]      vendor_id = '0;
  logic [LEN_W-1:0] cmd_rd_addr;
  logic [7:0]       cmd_rd_data;
  logic             txn_valid, txn_ready, txn_write, txn_fifo;
  logic [LEN_W-1:0] txn_len;
  logic [7:0]       wr_data, rd_data, rsp_data;
  logic             wr_valid, wr_ready, rd_valid, rd_ready;
  logic             rsp_valid, rsp_ready, busy, done;
  logic [2:0]       result;
  logic [LEN_W-1:0] rsp_len;

  tpm_fifo_sequencer #(.LEN_W(LEN_W), .POLL_CYCLES(POLL), .TIMEOUT_CYCLES(64'd200)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_size(cmd_size), .max_rsp(max_rsp),
    .vendor_id(vendor_id), .cmd_rd_addr(cmd_rd_addr), .cmd_rd_data(cmd_rd_data),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_write(txn_write),
    .txn_fifo(txn_fifo), .txn_len(txn_len), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .busy(busy),
    .done(done), .result(result), .rsp_len(rsp_len)
  );

  // Device model and bookkeeping
  logic [7:0] cmd_mem [0:63];
  logic [7:0] rsp_mem [0:63];
  logic [7:0] cmd_seen [0:63];
  logic [7:0] rsp_got [0:63];
  logic [7:0] sts_log [0:7];
  logic       m_clr = 1'b0, m_active = 1'b0, m_wr = 1'b0, m_fifo = 1'b0;
  logic [LEN_W-1:0] m_left = '0;
  int cyc = 0, rsp_ptr = 0, wr_cnt = 0, sts_wr_cnt = 0, sts_rd_cnt = 0;
  int fifo_rd_txn = 0, txn_cnt = 0, got_cnt = 0, last_poll = 0, min_gap = 1000000;
  int ready_after = 1, rsp_total = 0;
  logic f_mid = 1'b0, f_fin = 1'b0, bp_en = 1'b0;
  logic [7:0] sts_byte;

  assign cmd_rd_data = cmd_mem[cmd_rd_addr[5:0]];
  assign txn_ready   = !m_active && !m_clr;
  assign wr_ready    = m_active && m_wr && (cyc[1:0] != 2'b01);
  assign rd_valid    = m_active && !m_wr;
  assign rd_data     = m_fifo ? rsp_mem[rsp_ptr[5:0]] : sts_byte;
  assign rsp_ready   = !bp_en || cyc[0];

  always_comb begin
    if (sts_rd_cnt < ready_after)                sts_byte = 8'h80;
    else if (f_mid && rsp_ptr == rsp_total - 1)  sts_byte = 8'h80;
    else if (f_fin && rsp_ptr == rsp_total)      sts_byte = 8'h90;
    else if (rsp_ptr < rsp_total)                sts_byte = 8'h90;
    else                                         sts_byte = 8'h80;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (m_clr) begin
      rsp_ptr <= 0; wr_cnt <= 0; sts_wr_cnt <= 0; sts_rd_cnt <= 0; fifo_rd_txn <= 0;
      txn_cnt <= 0; got_cnt <= 0; min_gap <= 1000000; m_active <= 1'b0;
    end else begin
      if (txn_valid && txn_ready) begin
        m_active <= 1'b1; m_wr <= txn_write; m_fifo <= txn_fifo; m_left <= txn_len;
        txn_cnt  <= txn_cnt + 1;
        if (!txn_write && !txn_fifo) begin
          sts_rd_cnt <= sts_rd_cnt + 1;
          if (rsp_ptr == 0) begin
            if (sts_rd_cnt != 0 && (cyc - last_poll) < min_gap) min_gap <= cyc - last_poll;
            last_poll <= cyc;
          end
        end
        if (!txn_write && txn_fifo) fifo_rd_txn <= fifo_rd_txn + 1;
      end
      if (wr_valid && wr_ready) begin
        if (m_fifo) begin cmd_seen[wr_cnt[5:0]] <= wr_data; wr_cnt <= wr_cnt + 1; end
        else begin sts_log[sts_wr_cnt[2:0]] <= wr_data; sts_wr_cnt <= sts_wr_cnt + 1; end
        m_left <= m_left - 1'b1;
        if (m_left == 1) m_active <= 1'b0;
      end
      if (rd_valid && rd_ready) begin
        if (m_fifo) rsp_ptr <= rsp_ptr + 1;
        m_left <= m_left - 1'b1;
        if (m_left == 1) m_active <= 1'b0;
      end
      if (rsp_valid && rsp_ready) begin
        rsp_got[got_cnt[5:0]] <= rsp_data;
        got_cnt <= got_cnt + 1;
      end
    end
  end

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setup(input int csz, input int chdr, input int rlen, input int rtot,
                       input int rdy, input bit fm, input bit ff, input logic [15:0] vid,
                       input int mx, input bit bp);
    for (int i = 0; i < 64; i++) begin
      cmd_mem[i] = 8'(i * 3 + 1);
      rsp_mem[i] = 8'(i * 7 + 5);
    end
    cmd_mem[0] = 8'h80; cmd_mem[1] = 8'h01;
    cmd_mem[2] = 8'(chdr >> 24); cmd_mem[3] = 8'(chdr >> 16);
    cmd_mem[4] = 8'(chdr >> 8);  cmd_mem[5] = 8'(chdr);
    rsp_mem[0] = 8'h80; rsp_mem[1] = 8'h01;
    rsp_mem[2] = 8'(rlen >> 24); rsp_mem[3] = 8'(rlen >> 16);
    rsp_mem[4] = 8'(rlen >> 8);  rsp_mem[5] = 8'(rlen);
    @(negedge clk);
    cmd_size = LEN_W'(csz); max_rsp = LEN_W'(mx); vendor_id = vid;
    ready_after = rdy; rsp_total = rtot; f_mid = fm; f_fin = ff; bp_en = bp;
    m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0;
  endtask

  task automatic run(output bit seen_busy);
    seen_busy = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    seen_busy = busy;
    for (int n = 0; n < 5000 && !done; n++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(txn_valid == 1'b0, "R1 txn_valid", txn_valid, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_normal(input int csz, input int rl, input bit bp);
    bit b;
    int bad;
    setup(csz, csz, rl, rl, 3, 0, 0, 16'h1234, 48, bp);
    run(b);
    chk(b == 1'b1, "R10 busy during run", b, 1);
    chk(result == 3'd0, "R10 result ok", result, 0);
    chk(rsp_len == LEN_W'(rl), "R10 rsp_len", rsp_len, rl);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single pulse", done, 0);
    chk(sts_wr_cnt == 3, "R4 status write count", sts_wr_cnt, 3);
    chk(sts_log[0] == 8'h40, "R4 first status write", sts_log[0], 8'h40);
    chk(sts_log[1] == 8'h20, "R4 go write", sts_log[1], 8'h20);
    chk(sts_log[2] == 8'h40, "R10 idle write", sts_log[2], 8'h40);
    chk(wr_cnt == csz, "R4 command byte count", wr_cnt, csz);
    bad = 0;
    for (int i = 0; i < csz; i++) if (cmd_seen[i] != cmd_mem[i]) bad++;
    chk(bad == 0, "R4 command bytes", bad, 0);
    chk(got_cnt == rl, "R11 response byte count", got_cnt, rl);
    bad = 0;
    for (int i = 0; i < rl; i++) if (rsp_got[i] != rsp_mem[i]) bad++;
    chk(bad == 0, "R11 response bytes", bad, 0);
    chk(sts_rd_cnt == 5, "R5 status reads", sts_rd_cnt, 5);
    chk(min_gap >= POLL, "R5 poll spacing", min_gap, POLL);
    chk(fifo_rd_txn == ((rl == 7) ? 2 : 3), "R8 fifo read transactions", fifo_rd_txn,
        (rl == 7) ? 2 : 3);
  endtask

  task automatic t_reject();
    bit b;
    setup(10, 10, 12, 12, 1, 0, 0, 16'h0000, 48, 0);
    run(b);
    chk(result == 3'd1, "R2 uninit code", result, 1);
    chk(txn_cnt == 0, "R2 no bus activity", txn_cnt, 0);
    setup(10, 11, 12, 12, 1, 0, 0, 16'h1234, 48, 0);
    run(b);
    chk(result == 3'd2, "R3 mismatch code", result, 2);
    chk(txn_cnt == 0, "R3 no bus activity", txn_cnt, 0);
    setup(4, 4, 12, 12, 1, 0, 0, 16'h1234, 48, 0);
    run(b);
    chk(result == 3'd2, "R3 short command code", result, 2);
    chk(txn_cnt == 0, "R3 short no bus activity", txn_cnt, 0);
  endtask

  task automatic t_rsp_len();
    bit b;
    setup(10, 10, 40, 40, 1, 0, 0, 16'h1234, 32, 0);
    run(b);
    chk(result == 3'd4, "R7 too long code", result, 4);
    chk(got_cnt == 6, "R7 header streamed", got_cnt, 6);
    chk(sts_wr_cnt == 2, "R7 no idle write", sts_wr_cnt, 2);
    setup(10, 10, 6, 6, 1, 0, 0, 16'h1234, 32, 0);
    run(b);
    chk(result == 3'd4, "R7 too short code", result, 4);
  endtask

  task automatic t_timeout();
    bit b;
    setup(10, 10, 12, 12, 100000, 0, 0, 16'h1234, 48, 0);
    run(b);
    chk(result == 3'd3, "R6 timeout code", result, 3);
    chk(fifo_rd_txn == 0, "R6 no fifo read", fifo_rd_txn, 0);
    chk(sts_rd_cnt > 1, "R5 repeated polls", sts_rd_cnt, 2);
  endtask

  task automatic t_status_faults();
    bit b;
    setup(10, 10, 12, 12, 1, 1, 0, 16'h1234, 48, 0);
    run(b);
    chk(result == 3'd5, "R8 mid status code", result, 5);
    chk(got_cnt == 11, "R8 bytes before last", got_cnt, 11);
    setup(10, 10, 12, 12, 1, 0, 1, 16'h1234, 48, 0);
    run(b);
    chk(result == 3'd6, "R9 final status code", result, 6);
    chk(got_cnt == 12, "R9 last byte read", got_cnt, 12);
    chk(sts_wr_cnt == 2, "R9 no idle write", sts_wr_cnt, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_normal(10, 12, 0);
    t_normal(40, 7, 1);
    t_normal(6, 20, 1);
    t_reject();
    t_rsp_len();
    t_timeout();
    t_status_faults();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule